// File: doc/BRIEF.md
# Threshold Watchdog with Min/Max Capture

This block checks a stream of signed values against a low limit and a high limit. It runs on every sample it receives and does not depend on any conversion sequencing around it. The watched value comes from one of two sources, chosen by a select input:

- the final conversion results, taken directly;
- one raw one-bit serial channel out of several, passed through a small built-in Sinc decimation filter. The filter order can be 1 to 3 and the decimation ratio 1 to 32.

When a watched value lies outside the limits, the block does two things:

- It sets a sticky flag. The low direction and the high direction each have their own flag.
- It emits a one-cycle break pulse that downstream protection logic can act on at once.

Software clears each flag with a write-one-to-clear strobe.

Alongside the watchdog, a capture unit keeps the smallest and the largest final conversion result seen since the last refresh strobe. It does this whichever source the watchdog is using. A refresh loads the minimum register with the most positive code and the maximum register with the most negative code, so the next result replaces both.

Top module: `thresh_wdog`

## Requirements
- R1: With `src_sel` = 0, each `res_valid` sample is compared as a signed number. A value strictly greater than `thr_hi` sets `evt_hi`, and a value strictly less than `thr_lo` sets `evt_lo`. A value equal to a limit sets nothing. The flag is visible after the clock edge that takes the sample. If `thr_lo` > `thr_hi`, one value can set both flags.
- R2: `evt_lo` and `evt_hi` are sticky. Each one clears only when its own strobe (`clr_lo`, `clr_hi`) is high at a clock edge. If a new out-of-range sample arrives in the same cycle as the strobe, the flag stays set.
- R3: `brk_out` is high for exactly one cycle after each out-of-range sample, while the matching flag stays set.
- R4: `src_sel` chooses the watched source: 0 means final results, 1 means the filtered serial channel. Samples from the unselected source never set a flag or pulse `brk_out`.
- R5: `chan_sel` picks which bit of `ser_bits` feeds the filter. The filter advances only in cycles where `ser_tick` is high.
- R6: The filter maps a serial 1 to +1 and a 0 to -1. `flt_ord` sets the order: 1, 2 or 3, and a value of 0 acts as order 1. `flt_rdiv` holds the ratio R minus 1. For a constant input, the output settles at +R^N or -R^N and never goes past it.
- R7: Every `res_valid` sample updates `ext_min` and `ext_max` as a signed running minimum and maximum, whatever `src_sel` is. Without a sample or a refresh, both hold their values.
- R8: After reset, and after an `ext_clr` pulse with no sample, `ext_min` = 2^(DATA_W-1)-1 and `ext_max` = -2^(DATA_W-1).
- R9: If `ext_clr` and `res_valid` are high in the same cycle, both `ext_min` and `ext_max` take that sample.
- R10: After reset, `evt_lo`, `evt_hi` and `brk_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Final conversion result strobe |
| res_data | input | DATA_W | Final conversion result, signed |
| ser_tick | input | 1 | Serial bit strobe, common to all channels |
| ser_bits | input | NCH | One raw bit per serial channel |
| chan_sel | input | clog2(NCH) | Serial channel fed to the filter |
| src_sel | input | 1 | Watched source: 0 results, 1 filtered serial |
| flt_ord | input | 2 | Filter order (0 or 1 = first, 2, 3) |
| flt_rdiv | input | 5 | Decimation ratio minus one |
| thr_lo | input | DATA_W | Low limit, signed |
| thr_hi | input | DATA_W | High limit, signed |
| clr_lo | input | 1 | Write-one-to-clear for `evt_lo` |
| clr_hi | input | 1 | Write-one-to-clear for `evt_hi` |
| ext_clr | input | 1 | Refresh strobe for the min/max capture |
| evt_lo | output | 1 | Sticky below-limit flag |
| evt_hi | output | 1 | Sticky above-limit flag |
| brk_out | output | 1 | One-cycle break pulse |
| ext_min | output | DATA_W | Smallest result since refresh |
| ext_max | output | DATA_W | Largest result since refresh |

## Verification
The bench places samples exactly on each limit and one code beyond it, and uses the extreme codes of the data width. A comparator that is inclusive, or that compares unsigned, flags the wrong vectors. It strobes a clear together with a fresh violation, and refreshes the capture together with a sample. A design that lets the clear win loses an event, and one that drops the coincident sample leaves the sentinel codes in place. For the filter it drives constant inputs for order/ratio pairs up to 3 and 32 and sets the limit at the settled gain and one below it. A wrong stage tap or ratio count shows up as a missing or spurious flag, and so does too narrow an accumulator, which wraps at 32768. It also runs out-of-range results while the serial source is selected, where a broken source mux raises a flag.

// File: rtl/twd_pkg.sv
// Package: shared sizes and the source encoding for the threshold watchdog.
// Assumes the filter never exceeds third order and a ratio of 32.
package twd_pkg;
    localparam int ORD_MAX   = 3;
    localparam int RATIO_MAX = 32;
    localparam int ORD_W     = 2;
    localparam int RDIV_W    = $clog2(RATIO_MAX);
    // Worst case gain RATIO_MAX**ORD_MAX needs this many signed bits.
    localparam int FILT_W    = ORD_MAX * RDIV_W + 2;

    typedef enum logic {
        SRC_RESULT = 1'b0,
        SRC_SERIAL = 1'b1
    } wd_src_e;
endpackage

// File: rtl/twd_sinc.sv
// Module: twd_sinc
// Sinc (CIC) decimator for one serial bit stream, order 1..NST, ratio
// 1..2**RW. Bits map to +1/-1. The integrators and combs wrap modulo
// 2**W. This is exact because W holds the largest gain.
// Assumes NST = 3, so a 2-bit order field indexes the stages safely.
module twd_sinc
    import twd_pkg::*;
#(
    parameter int W   = FILT_W,
    parameter int NST = ORD_MAX,
    parameter int RW  = RDIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_tick,
    input  logic                in_bit,
    input  logic [ORD_W-1:0]    ord,
    input  logic [RW-1:0]       rdiv,
    output logic                out_valid,
    output logic signed [W-1:0] out_data
);
    logic signed [W-1:0] integ_q [NST];
    logic signed [W-1:0] dly_q   [NST];
    logic signed [W-1:0] cmb     [NST];
    logic signed [W-1:0] x_pm;
    logic signed [W-1:0] c_in;
    logic [RW-1:0]       cnt_q;
    logic [ORD_W-1:0]    ord_idx;
    logic                dec_hit;

    // Map the serial bit to +1 / -1.
    assign x_pm = {{(W-1){~in_bit}}, 1'b1};

    // Stage index from the order field, 0 acting as first order.
    always_comb begin
        if (ord == '0) ord_idx = '0;
        else           ord_idx = ord - 1'b1;
    end

    assign dec_hit = in_tick && (cnt_q == rdiv);
    assign c_in    = integ_q[ord_idx];

    // Decimation phase counter over input ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (dec_hit) cnt_q <= '0;
        else if (in_tick) cnt_q <= cnt_q + 1'b1;
    end

    // Integrator cascade running at the input rate.
    for (genvar k = 0; k < NST; k++) begin : g_int
        logic signed [W-1:0] stage_in;
        if (k == 0) begin : g_first
            assign stage_in = x_pm;
        end else begin : g_next
            assign stage_in = integ_q[k-1];
        end
        // Accumulate this stage on every input tick.
        always_ff @(posedge clk) begin
            if (!rst_n)       integ_q[k] <= '0;
            else if (in_tick) integ_q[k] <= integ_q[k] + stage_in;
        end
    end

    // Comb cascade evaluated at the decimated rate.
    always_comb begin
        cmb[0] = c_in - dly_q[0];
        for (int k = 1; k < NST; k++) cmb[k] = cmb[k-1] - dly_q[k];
    end

    for (genvar k = 0; k < NST; k++) begin : g_cmb
        logic signed [W-1:0] comb_in;
        if (k == 0) begin : g_first
            assign comb_in = c_in;
        end else begin : g_next
            assign comb_in = cmb[k-1];
        end
        // Store the comb delay on each decimated output.
        always_ff @(posedge clk) begin
            if (!rst_n)       dly_q[k] <= '0;
            else if (dec_hit) dly_q[k] <= comb_in;
        end
    end

    // Register the selected comb output and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= dec_hit;
            if (dec_hit) out_data <= cmb[ord_idx];
        end
    end
endmodule

// File: rtl/twd_limit.sv
// Module: twd_limit
// Signed window compare with sticky per-direction flags and a one-cycle
// break pulse. A new violation outranks a same-cycle clear strobe.
module twd_limit #(
    parameter int DW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp,
    input  logic signed [DW-1:0] thr_lo,
    input  logic signed [DW-1:0] thr_hi,
    input  logic                 clr_lo,
    input  logic                 clr_hi,
    output logic                 evt_lo,
    output logic                 evt_hi,
    output logic                 brk
);
    logic below, above;

    // Strict compare of the presented sample against both limits.
    always_comb begin
        below = smp_valid && (smp < thr_lo);
        above = smp_valid && (smp > thr_hi);
    end

    // Sticky flags with write-one-to-clear and the break pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_lo <= 1'b0;
            evt_hi <= 1'b0;
            brk    <= 1'b0;
        end else begin
            evt_lo <= below | (evt_lo & ~clr_lo);
            evt_hi <= above | (evt_hi & ~clr_hi);
            brk    <= below | above;
        end
    end
endmodule

// File: rtl/twd_extremes.sv
// Module: twd_extremes
// Running signed minimum and maximum of the final results. A refresh loads
// the sentinels, or the coincident sample if there is one.
module twd_extremes #(
    parameter int DW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp,
    input  logic                 refresh,
    output logic signed [DW-1:0] min_q,
    output logic signed [DW-1:0] max_q
);
    localparam logic signed [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    // Track or reload the extremes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= MOST_POS;
            max_q <= MOST_NEG;
        end else if (refresh) begin
            min_q <= smp_valid ? smp : MOST_POS;
            max_q <= smp_valid ? smp : MOST_NEG;
        end else if (smp_valid) begin
            if (smp < min_q) min_q <= smp;
            if (smp > max_q) max_q <= smp;
        end
    end
endmodule

// File: rtl/thresh_wdog.sv
// Module: thresh_wdog (top)
// Threshold watchdog over either the final results or a Sinc-filtered
// serial channel, plus a min/max capture of the final results.
// Assumes DATA_W is wider than the filter word, so the filter sign-extends.
module thresh_wdog
    import twd_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int NCH    = 8,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_valid,
    input  logic signed [DATA_W-1:0] res_data,
    input  logic                     ser_tick,
    input  logic [NCH-1:0]           ser_bits,
    input  logic [CH_W-1:0]          chan_sel,
    input  logic                     src_sel,
    input  logic [ORD_W-1:0]         flt_ord,
    input  logic [RDIV_W-1:0]        flt_rdiv,
    input  logic signed [DATA_W-1:0] thr_lo,
    input  logic signed [DATA_W-1:0] thr_hi,
    input  logic                     clr_lo,
    input  logic                     clr_hi,
    input  logic                     ext_clr,
    output logic                     evt_lo,
    output logic                     evt_hi,
    output logic                     brk_out,
    output logic signed [DATA_W-1:0] ext_min,
    output logic signed [DATA_W-1:0] ext_max
);
    wd_src_e                    src;
    logic                       sel_bit;
    logic                       flt_valid;
    logic signed [FILT_W-1:0]   flt_data;
    logic signed [DATA_W-1:0]   flt_ext;
    logic                       wd_valid;
    logic signed [DATA_W-1:0]   wd_data;

    assign src     = wd_src_e'(src_sel);
    assign sel_bit = ser_bits[chan_sel];
    assign flt_ext = {{(DATA_W-FILT_W){flt_data[FILT_W-1]}}, flt_data};

    twd_sinc #(.W(FILT_W), .NST(ORD_MAX), .RW(RDIV_W)) u_sinc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_tick   (ser_tick),
        .in_bit    (sel_bit),
        .ord       (flt_ord),
        .rdiv      (flt_rdiv),
        .out_valid (flt_valid),
        .out_data  (flt_data)
    );

    // Route the selected source to the comparator.
    always_comb begin
        if (src == SRC_SERIAL) begin
            wd_valid = flt_valid;
            wd_data  = flt_ext;
        end else begin
            wd_valid = res_valid;
            wd_data  = res_data;
        end
    end

    twd_limit #(.DW(DATA_W)) u_limit (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (wd_valid),
        .smp       (wd_data),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .clr_lo    (clr_lo),
        .clr_hi    (clr_hi),
        .evt_lo    (evt_lo),
        .evt_hi    (evt_hi),
        .brk       (brk_out)
    );

    twd_extremes #(.DW(DATA_W)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (res_valid),
        .smp       (res_data),
        .refresh   (ext_clr),
        .min_q     (ext_min),
        .max_q     (ext_max)
    );
endmodule

// File: rtl/twd_checker.sv
// Module: twd_checker
// Port-level properties of thresh_wdog, attached with bind below.
module twd_checker #(
    parameter int DATA_W = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     res_valid,
    input logic signed [DATA_W-1:0] res_data,
    input logic                     src_sel,
    input logic                     clr_lo,
    input logic                     clr_hi,
    input logic                     ext_clr,
    input logic                     evt_lo,
    input logic                     evt_hi,
    input logic                     brk_out,
    input logic signed [DATA_W-1:0] ext_min,
    input logic signed [DATA_W-1:0] ext_max
);
    localparam logic signed [DATA_W-1:0] TOP = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] BOT = {1'b1, {(DATA_W-1){1'b0}}};

    // R3
    brk_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_out |-> (evt_lo || evt_hi));
    // R2
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_lo && !clr_lo) |=> evt_lo);
    // R2
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hi && !clr_hi) |=> evt_hi);
    // R3
    lo_rise_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_lo) |-> brk_out);
    // R3
    hi_rise_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_hi) |-> brk_out);
    // R4
    src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !src_sel) |=> !brk_out);
    // R7
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clr && !res_valid) |=> ($stable(ext_min) && $stable(ext_max)));
    // R7
    ext_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !ext_clr) |=>
            (ext_min <= $past(res_data) && ext_max >= $past(res_data)));
    // R8
    ext_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clr && !res_valid) |=> (ext_min == TOP && ext_max == BOT));
    // R9
    ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clr && res_valid) |=>
            (ext_min == $past(res_data) && ext_max == $past(res_data)));
endmodule

bind thresh_wdog twd_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .src_sel   (src_sel),
    .clr_lo    (clr_lo),
    .clr_hi    (clr_hi),
    .ext_clr   (ext_clr),
    .evt_lo    (evt_lo),
    .evt_hi    (evt_hi),
    .brk_out   (brk_out),
    .ext_min   (ext_min),
    .ext_max   (ext_max)
);

// File: tb/thresh_wdog_test.sv
module thresh_wdog_test;
    localparam int DW  = 24;
    localparam int NCH = 8;
    localparam int NV  = 10;
    localparam int TOPV = 8388607;
    localparam int BOTV = -8388608;

    // Direct-path vectors: low limit, high limit, sample, expected {hi,lo}.
    localparam int V_LO  [NV] = '{-100, -100, -100, -100, -100, -100, -100, 50, 10, -5};
    localparam int V_HI  [NV] = '{ 100,  100,  100,  100,  100,  100,  100, 60,  5, -5};
    localparam int V_D   [NV] = '{   0,  100,  101, -100, -101, BOTV, TOPV, 55,  7, -5};
    localparam int V_EXP [NV] = '{   0,    0,    2,    0,    1,    1,    2,  0,  3,  0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_valid = 1'b0;
    logic signed [DW-1:0] res_data = '0;
    logic ser_tick = 1'b0;
    logic [NCH-1:0] ser_bits = '0;
    logic [2:0] chan_sel = '0;
    logic src_sel = 1'b0;
    logic [1:0] flt_ord = 2'd1;
    logic [4:0] flt_rdiv = '0;
    logic signed [DW-1:0] thr_lo = '0;
    logic signed [DW-1:0] thr_hi = '0;
    logic clr_lo = 1'b0, clr_hi = 1'b0, ext_clr = 1'b0;
    logic evt_lo, evt_hi, brk_out;
    logic signed [DW-1:0] ext_min, ext_max;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thresh_wdog #(.DATA_W(DW), .NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .ser_tick(ser_tick), .ser_bits(ser_bits), .chan_sel(chan_sel),
        .src_sel(src_sel), .flt_ord(flt_ord), .flt_rdiv(flt_rdiv),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .clr_lo(clr_lo), .clr_hi(clr_hi),
        .ext_clr(ext_clr), .evt_lo(evt_lo), .evt_hi(evt_hi), .brk_out(brk_out),
        .ext_min(ext_min), .ext_max(ext_max)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One sample on the result path, then check at the next falling edge.
    task automatic put_result(input int d);
        res_data  = DW'(d);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // Filter test: constant serial input, settle, then check both flags (R5, R6).
    task automatic run_filt(input logic [1:0] ordf, input int r, input int ch,
                            input logic [7:0] bits, input int lo, input int hi,
                            input bit exp_lo, input bit exp_hi, input string tag);
        int n_eff;
        n_eff = (ordf == 2'd0) ? 1 : int'(ordf);
        flt_ord  = ordf;
        flt_rdiv = 5'(r - 1);
        chan_sel = 3'(ch);
        ser_bits = bits;
        thr_lo   = DW'(lo);
        thr_hi   = DW'(hi);
        src_sel  = 1'b1;
        ser_tick = 1'b1;
        do_reset();
        repeat (r * (n_eff + 3) + 10) @(negedge clk);
        chk(evt_lo == exp_lo, {tag, " lo flag"}, evt_lo, exp_lo);
        chk(evt_hi == exp_hi, {tag, " hi flag"}, evt_hi, exp_hi);
        ser_tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired (all requirements) act=%0d exp=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int emin, emax, ev;
        do_reset();
        @(negedge clk);
        // R10 / R8: reset state
        chk(evt_lo == 1'b0, "R10 evt_lo reset", evt_lo, 0);
        chk(evt_hi == 1'b0, "R10 evt_hi reset", evt_hi, 0);
        chk(brk_out == 1'b0, "R10 brk reset", brk_out, 0);
        chk(ext_min == DW'(TOPV), "R8 min reset", ext_min, TOPV);
        chk(ext_max == DW'(BOTV), "R8 max reset", ext_max, BOTV);

        // R1 / R3: vector table over the result path
        emin = TOPV;
        emax = BOTV;
        for (int i = 0; i < NV; i++) begin
            clr_lo = 1'b1;
            clr_hi = 1'b1;
            thr_lo = DW'(V_LO[i]);
            thr_hi = DW'(V_HI[i]);
            @(negedge clk);
            clr_lo = 1'b0;
            clr_hi = 1'b0;
            put_result(V_D[i]);
            ev = V_EXP[i];
            chk(evt_lo == ev[0], "R1 lo flag vector", evt_lo, ev[0]);
            chk(evt_hi == ev[1], "R1 hi flag vector", evt_hi, ev[1]);
            chk(brk_out == (ev != 0), "R3 brk vector", brk_out, ev != 0);
            if (V_D[i] < emin) emin = V_D[i];
            if (V_D[i] > emax) emax = V_D[i];
        end
        // R7: running extremes over the table
        chk(ext_min == DW'(emin), "R7 min after table", ext_min, emin);
        chk(ext_max == DW'(emax), "R7 max after table", ext_max, emax);

        // R2 / R3: sticky flag, pulse width, clear against set
        thr_lo = -24'sd100;
        thr_hi = 24'sd100;
        put_result(500);
        chk(evt_hi == 1'b1, "R2 hi set", evt_hi, 1);
        chk(brk_out == 1'b1, "R3 brk pulse", brk_out, 1);
        @(negedge clk);
        chk(brk_out == 1'b0, "R3 brk one cycle", brk_out, 0);
        chk(evt_hi == 1'b1, "R2 hi holds", evt_hi, 1);
        clr_hi = 1'b1;
        put_result(600);
        clr_hi = 1'b0;
        chk(evt_hi == 1'b1, "R2 set wins over clear", evt_hi, 1);
        clr_hi = 1'b1;
        @(negedge clk);
        clr_hi = 1'b0;
        chk(evt_hi == 1'b0, "R2 hi cleared", evt_hi, 0);
        clr_lo = 1'b1;
        put_result(-700);
        clr_lo = 1'b0;
        chk(evt_lo == 1'b1, "R2 lo set wins", evt_lo, 1);
        clr_lo = 1'b1;
        @(negedge clk);
        clr_lo = 1'b0;
        chk(evt_lo == 1'b0, "R2 lo cleared", evt_lo, 0);

        // R8: refresh with no sample
        ext_clr = 1'b1;
        @(negedge clk);
        ext_clr = 1'b0;
        chk(ext_min == DW'(TOPV), "R8 min refresh", ext_min, TOPV);
        chk(ext_max == DW'(BOTV), "R8 max refresh", ext_max, BOTV);

        // R4 / R7: serial source selected, results ignored by watchdog but tracked
        src_sel = 1'b1;
        put_result(1000);
        chk(evt_hi == 1'b0 && evt_lo == 1'b0, "R4 result ignored", {evt_hi, evt_lo}, 0);
        chk(brk_out == 1'b0, "R4 no brk", brk_out, 0);
        chk(ext_min == 24'sd1000 && ext_max == 24'sd1000, "R7 tracked on serial src", ext_min, 1000);

        // R9: refresh coincident with a sample
        ext_clr = 1'b1;
        put_result(-42);
        ext_clr = 1'b0;
        chk(ext_min == -24'sd42, "R9 min takes sample", ext_min, -42);
        chk(ext_max == -24'sd42, "R9 max takes sample", ext_max, -42);
        put_result(7);
        chk(ext_min == -24'sd42 && ext_max == 24'sd7, "R7 min/max after refresh", ext_max, 7);
        src_sel = 1'b0;

        // R6 / R5: filtered serial path at settled gain boundaries
        run_filt(2'd1, 1,  0, 8'h01, -100000, 0,      1'b0, 1'b1, "R6 ord1 r1 ones hi=0");
        run_filt(2'd1, 1,  0, 8'h01, -100000, 1,      1'b0, 1'b0, "R6 ord1 r1 ones hi=1");
        run_filt(2'd2, 4,  5, 8'h20, -100000, 15,     1'b0, 1'b1, "R5 ch5 ord2 r4 hi=15");
        run_filt(2'd2, 4,  5, 8'h20, -100000, 16,     1'b0, 1'b0, "R6 ord2 r4 hi=16");
        run_filt(2'd2, 4,  2, 8'h20, -15,     100000, 1'b1, 1'b0, "R5 ch2 zeros lo=-15");
        run_filt(2'd3, 32, 0, 8'h00, -32767,  100000, 1'b1, 1'b0, "R6 ord3 r32 lo=-32767");
        run_filt(2'd3, 32, 0, 8'h00, -32768,  100000, 1'b0, 1'b0, "R6 ord3 r32 lo=-32768");
        run_filt(2'd0, 8,  1, 8'h02, -100000, 7,      1'b0, 1'b1, "R6 ord0 as 1 r8 hi=7");
        run_filt(2'd3, 8,  7, 8'h80, -100000, 512,    1'b0, 1'b0, "R6 ord3 r8 hi=512");
        run_filt(2'd3, 8,  7, 8'h80, -100000, 511,    1'b0, 1'b1, "R6 ord3 r8 hi=511");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule